// File: doc/BRIEF.md
# Dual-Rate Character Serializer

This block takes 10-bit characters that are already line-coded and turns them into one serial bit stream. The characters come in on two lanes and are paced by a slow byte clock. The block does no encoding of its own: a character reaches the line exactly as it was presented, apart from one case. When the active-low comma control is asserted, the character on lane 0 is replaced by a fixed comma code.

Everything runs on one fast clock `clk_i`, at the high serial rate, which is twenty cycles per byte-clock period. The byte clock is sampled as a level, and its rising and falling edges are found inside the block.

There are three capture modes:
- **Low-rate mode:** one character per byte period. Each bit is held for two fast cycles.
- **High-rate mode:** two characters on every rising byte edge, sent as one bit per fast cycle.
- **Ping-pong mode:** the high-rate mode with a split capture. Lane 0 is taken on the rising byte edge and lane 1 half a byte period later, on the falling edge.

`ser_vld_o` marks each cycle in which `ser_o` carries a new bit.

Top module: `txser_top`

## Requirements
- R1: With `rate_hi_i`=0, each rising byte-clock edge captures one character from lane 0, and exactly 10 bits go out. Lane 1 and `pingpong_i` have no effect on the stream.
- R2: With `rate_hi_i`=1 and `pingpong_i`=0, each rising byte-clock edge captures both lanes, and 20 bits go out.
- R3: With `rate_hi_i`=1 and `pingpong_i`=1, lane 0 is captured at the rising byte-clock edge and lane 1 at the following falling edge. The value on lane 1 at the rising edge is not used.
- R4: When `comma_n_i`=0 at a rising byte-clock edge, the lane 0 value is not used. In its place the block sends the comma whose bits, in send order, are 0,0,1,1,1,1,1,0,1,0 (as a vector, bit 0 first: 10'b0101111100). Lane 1 is unaffected.
- R5: Apart from R4, the characters are passed through bit for bit, with no coding applied.
- R6: Bit 0 of a character is sent first and bit 9 last. In the two-character modes, lane 0 is sent completely before lane 1.
- R7: High-rate characters send one bit per `clk_i` cycle. Low-rate bits are spaced exactly two cycles apart, and a low-rate bit never directly follows another valid bit.
- R8: `rate_hi_i`, `pingpong_i`, `comma_n_i` and lane 0 are sampled only at the rising byte-clock edge. Changing them later in the byte period neither alters nor truncates any character.
- R9: While `rst_n_i` is low at a clock edge, `ser_vld_o` and `ser_o` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one cycle per high-rate bit |
| rst_n_i | input | 1 | Synchronous reset, active low |
| byte_clk_i | input | 1 | Byte clock, sampled as a level |
| lane0_i | input | 10 | First character lane |
| lane1_i | input | 10 | Second character lane |
| rate_hi_i | input | 1 | 1 selects two characters per byte period |
| pingpong_i | input | 1 | 1 selects the split (half-period) capture of lane 1 |
| comma_n_i | input | 1 | Low replaces lane 0 with the comma code |
| ser_o | output | 1 | Serial bit |
| ser_vld_o | output | 1 | High when `ser_o` holds a new bit |

## Verification
Internal faults show up at the ports within one byte period:
- A wrong bit counter or shift register lengthens or shortens the character stream. The total bit count per scenario shows this.
- A wrong pacing toggle changes the spacing between valid strobes on the very next bit.
- A stale hold register or a wrong edge detector makes the received bits differ from the expected lane values. The ping-pong lane 1 check exposes this at once, because lane 1 carries an inverted decoy until the falling edge.

The mode-switch scenario changes the selects in the middle of a period. A premature sample would therefore alter the count or the spacing in that same period.

// File: rtl/txser_pkg.sv
// Shared constants and types for the dual-rate character serializer.
package txser_pkg;
    localparam int CHAR_W  = 10;
    localparam int FRAME_W = 2 * CHAR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    // Comma code, bit 0 is sent first: 0,0,1,1,1,1,1,0,1,0
    localparam logic [CHAR_W-1:0] COMMA_K = 10'b0101111100;

    typedef struct packed {
        logic              two;  // frame carries both lanes
        logic [CHAR_W-1:0] c1;   // second character (zero in low-rate)
        logic [CHAR_W-1:0] c0;   // first character
    } frame_t;
endpackage

// File: rtl/txser_edge.sv
// Byte-clock edge finder.
// Assumes the byte clock is slow and stable relative to clk_i (at least 2 cycles per level).
module txser_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_q;

    // Remember the previous sampled level
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) lvl_q <= 1'b0;
        else          lvl_q <= lvl_i;
    end

    // Edge pulses are one cycle wide
    always_comb begin
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end
endmodule

// File: rtl/txser_capture.sv
// Character capture stage.
// Samples the lanes and mode selects at byte-clock edges and builds one frame per byte period.
// The frame is held until the shifter takes it.
// Assumes the shifter drains each frame before the next byte period completes.
module txser_capture
    import txser_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [CHAR_W-1:0] lane0_i,
    input  logic [CHAR_W-1:0] lane1_i,
    input  logic              rate_hi_i,
    input  logic              pingpong_i,
    input  logic              comma_n_i,
    input  logic              take_i,
    output logic              frm_v_o,
    output frame_t            frm_o
);
    logic [CHAR_W-1:0] first_c;
    logic [CHAR_W-1:0] stage_q;
    logic              wait_fall_q;

    // Lane 0 or the comma code, chosen at the rising edge
    always_comb begin
        first_c = comma_n_i ? lane0_i : COMMA_K;
    end

    // Capture lanes on byte edges; hold the frame until taken
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            frm_v_o     <= 1'b0;
            frm_o       <= '0;
            stage_q     <= '0;
            wait_fall_q <= 1'b0;
        end else if (rise_i) begin
            if (!rate_hi_i) begin
                frm_o       <= '{two: 1'b0, c1: '0, c0: first_c};
                frm_v_o     <= 1'b1;
                wait_fall_q <= 1'b0;
            end else if (!pingpong_i) begin
                frm_o       <= '{two: 1'b1, c1: lane1_i, c0: first_c};
                frm_v_o     <= 1'b1;
                wait_fall_q <= 1'b0;
            end else begin
                stage_q     <= first_c;
                wait_fall_q <= 1'b1;
                if (take_i) frm_v_o <= 1'b0;
            end
        end else if (fall_i && wait_fall_q) begin
            frm_o       <= '{two: 1'b1, c1: lane1_i, c0: stage_q};
            frm_v_o     <= 1'b1;
            wait_fall_q <= 1'b0;
        end else if (take_i) begin
            frm_v_o <= 1'b0;
        end
    end
endmodule

// File: rtl/txser_shift.sv
// Frame shifter.
// Sends bit 0 of lane 0 first.
// A two-lane frame sends one bit per cycle; a one-lane frame sends one bit every second cycle.
// A new frame is taken on the cycle the previous one sends its last bit.
module txser_shift
    import txser_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_n_i,
    input  logic   frm_v_i,
    input  frame_t frm_i,
    output logic   take_o,
    output logic   ser_o,
    output logic   ser_vld_o,
    output logic   bit_hi_o
);
    localparam logic [CNT_W-1:0] N_ONE = CNT_W'(CHAR_W);
    localparam logic [CNT_W-1:0] N_TWO = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               active_q;
    logic               hi_q;
    logic               div_q;
    logic               step;
    logic               last;

    // Bit step and end-of-frame detection
    always_comb begin
        step   = active_q & (hi_q | div_q);
        last   = step & (cnt_q == CNT_W'(1));
        take_o = frm_v_i & (~active_q | last);
    end

    // Shift out bits and load the next frame
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sreg_q    <= '0;
            cnt_q     <= '0;
            active_q  <= 1'b0;
            hi_q      <= 1'b0;
            div_q     <= 1'b0;
            ser_o     <= 1'b0;
            ser_vld_o <= 1'b0;
            bit_hi_o  <= 1'b0;
        end else begin
            ser_vld_o <= 1'b0;
            if (active_q) begin
                div_q <= ~div_q;
                if (step) begin
                    ser_o     <= sreg_q[0];
                    ser_vld_o <= 1'b1;
                    bit_hi_o  <= hi_q;
                    sreg_q    <= sreg_q >> 1;
                    cnt_q     <= cnt_q - CNT_W'(1);
                    if (last) active_q <= 1'b0;
                end
            end
            if (take_o) begin
                sreg_q   <= {frm_i.c1, frm_i.c0};
                cnt_q    <= frm_i.two ? N_TWO : N_ONE;
                hi_q     <= frm_i.two;
                active_q <= 1'b1;
                div_q    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/txser_top.sv
// Dual-rate character serializer, top level.
// Finds byte-clock edges, captures one frame per byte period and shifts it out on clk_i.
// Assumes clk_i runs at 2*CHAR_W cycles per byte-clock period.
module txser_top
    import txser_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              byte_clk_i,
    input  logic [CHAR_W-1:0] lane0_i,
    input  logic [CHAR_W-1:0] lane1_i,
    input  logic              rate_hi_i,
    input  logic              pingpong_i,
    input  logic              comma_n_i,
    output logic              ser_o,
    output logic              ser_vld_o
);
    logic   rise;
    logic   fall;
    logic   frm_v;
    frame_t frm;
    logic   take;
    logic   bit_hi;

    txser_edge u_edge (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .lvl_i   (byte_clk_i),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    txser_capture u_cap (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .lane0_i    (lane0_i),
        .lane1_i    (lane1_i),
        .rate_hi_i  (rate_hi_i),
        .pingpong_i (pingpong_i),
        .comma_n_i  (comma_n_i),
        .take_i     (take),
        .frm_v_o    (frm_v),
        .frm_o      (frm)
    );

    txser_shift u_shift (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .frm_v_i   (frm_v),
        .frm_i     (frm),
        .take_o    (take),
        .ser_o     (ser_o),
        .ser_vld_o (ser_vld_o),
        .bit_hi_o  (bit_hi)
    );
endmodule

// File: rtl/txser_chk.sv
// Property checker for txser_top, attached by bind.
module txser_chk
    import txser_pkg::*;
(
    input logic   clk_i,
    input logic   rst_n_i,
    input logic   byte_clk_i,
    input logic   rate_hi_i,
    input logic   pingpong_i,
    input logic   comma_n_i,
    input logic   frm_v,
    input frame_t frm,
    input logic   take,
    input logic   ser_vld_o,
    input logic   bit_hi
);
    logic bq;
    logic up;

    // Own copy of the previous byte-clock level
    always_ff @(posedge clk_i) bq <= byte_clk_i;
    assign up = byte_clk_i & ~bq;

    // R9: no valid bit on the first cycle after reset release
    p_quiet_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_n_i) |-> !ser_vld_o);

    // R7: back-to-back valid bits only for high-rate characters
    p_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ser_vld_o && $past(ser_vld_o)) |-> bit_hi);

    // R8: a pending frame is never overwritten before it is taken
    p_hold_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (frm_v && !take) |=> (frm_v && $stable(frm)));

    // R1: a low-rate rising edge yields a one-lane frame
    p_single_lane_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (up && !rate_hi_i) |=> (frm_v && !frm.two));

    // R4: comma replaces lane 0 when the control is low
    p_comma_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (up && !comma_n_i && !(rate_hi_i && pingpong_i)) |=> (frm.c0 == COMMA_K));
endmodule

bind txser_top txser_chk u_chk (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .byte_clk_i (byte_clk_i),
    .rate_hi_i  (rate_hi_i),
    .pingpong_i (pingpong_i),
    .comma_n_i  (comma_n_i),
    .frm_v      (frm_v),
    .frm        (frm),
    .take       (take),
    .ser_vld_o  (ser_vld_o),
    .bit_hi     (bit_hi)
);

// File: tb/txser_top_tb_top.sv
// Directed bench for txser_top: one task per scenario, each checking its own stream.
module txser_top_tb_top;
    localparam int HALF = 10;            // fast cycles per byte-clock level
    localparam logic [9:0] K = 10'b0101111100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_clk = 1'b0;
    logic [9:0] lane0 = '0, lane1 = '0;
    logic rate_hi = 1'b0, pp = 1'b0, comma_n = 1'b1;
    logic ser, ser_vld;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic rec_bit [0:1023];
    int   rec_t   [0:1023];
    int   rec_n = 0;
    logic exp_bit [0:1023];
    int   exp_gap [0:1023];
    int   exp_n = 0;
    int   base = 0;

    always #2.5 clk = ~clk;

    txser_top dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .byte_clk_i(byte_clk),
        .lane0_i(lane0), .lane1_i(lane1), .rate_hi_i(rate_hi),
        .pingpong_i(pp), .comma_n_i(comma_n),
        .ser_o(ser), .ser_vld_o(ser_vld)
    );

    // Cycle counter and serial collector, sampled mid-cycle
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (ser_vld && rec_n < 1024) begin
            rec_bit[rec_n] <= ser;
            rec_t[rec_n]   <= cyc;
            rec_n          <= rec_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_char(input logic [9:0] c, input int gap);
        for (int i = 0; i < 10; i++) begin
            exp_bit[exp_n] = c[i];
            exp_gap[exp_n] = (i == 0) ? 0 : gap;
            exp_n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_scn();
        idle(4);
        base  = rec_n;
        exp_n = 0;
    endtask

    // One byte period; flip changes the selects and lane 0 right after the rising edge
    task automatic send(input logic [9:0] l0, input logic [9:0] l1, input bit hi,
                        input bit p, input bit cn, input bit flip);
        @(negedge clk);
        lane0 = l0; lane1 = p ? ~l1 : l1; rate_hi = hi; pp = p; comma_n = cn;
        byte_clk = 1'b1;
        @(negedge clk);
        if (flip) begin rate_hi = ~hi; pp = ~p; comma_n = ~cn; lane0 = ~l0; end
        idle(HALF - 2);
        @(negedge clk);
        byte_clk = 1'b0;
        lane1 = p ? l1 : ~l1;
        @(negedge clk);
        lane1 = ~l1;
        idle(HALF - 2);
        if (!cn) push_char(K, hi ? 1 : 2); else push_char(l0, hi ? 1 : 2);
        if (hi) begin
            exp_gap[exp_n] = 1;
            push_char(l1, 1);
            exp_gap[exp_n - 10] = 1;
        end
    endtask

    task automatic end_scn(input string req);
        int bad_bits = 0, bad_gap = 0, fb = -1, fa = 0, fe = 0;
        idle(60);
        check(rec_n - base == exp_n, req, "bit count", rec_n - base, exp_n);
        for (int i = 0; i < exp_n && base + i < rec_n; i++) begin
            if (rec_bit[base + i] !== exp_bit[i]) begin
                bad_bits++;
                if (fb < 0) begin fb = i; fa = int'(rec_bit[base + i]); fe = int'(exp_bit[i]); end
            end
            if (i > 0 && exp_gap[i] != 0 && rec_t[base + i] - rec_t[base + i - 1] != exp_gap[i])
                bad_gap++;
        end
        check(bad_bits == 0, req, $sformatf("bit values (first bad index %0d)", fb), fa, fe);
        check(bad_gap == 0, req, "bit spacing errors", bad_gap, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(5);
        check(ser_vld == 1'b0, "R9", "valid during reset", int'(ser_vld), 0);
        check(ser == 1'b0, "R9", "serial during reset", int'(ser), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_low();       // R1 R5 R6 R7
        start_scn();
        send(10'h2A5, 10'h3FF, 0, 0, 1, 0);
        send(10'h001, 10'h155, 0, 1, 1, 0);
        send(10'h200, 10'h0F0, 0, 0, 1, 0);
        send(10'h1C7, 10'h2AA, 0, 1, 1, 0);
        end_scn("R1/R5/R6/R7 low-rate");
    endtask

    task automatic t_high();      // R2 R6 R7
        start_scn();
        send(10'h3C1, 10'h00F, 1, 0, 1, 0);
        send(10'h001, 10'h200, 1, 0, 1, 0);
        send(10'h155, 10'h2AA, 1, 0, 1, 0);
        end_scn("R2/R6/R7 high-rate");
    endtask

    task automatic t_pp();        // R3
        start_scn();
        send(10'h0A3, 10'h35C, 1, 1, 1, 0);
        send(10'h3FF, 10'h000, 1, 1, 1, 0);
        send(10'h111, 10'h2EE, 1, 1, 1, 0);
        end_scn("R3 ping-pong");
    endtask

    task automatic t_comma();     // R4
        start_scn();
        send(10'h3FF, 10'h000, 0, 0, 0, 0);
        send(10'h000, 10'h1A5, 1, 0, 0, 0);
        send(10'h2B4, 10'h0C3, 1, 1, 0, 0);
        end_scn("R4 comma insert");
    endtask

    task automatic t_switch();    // R8
        start_scn();
        send(10'h123, 10'h321, 0, 0, 1, 1);
        send(10'h0F0, 10'h30F, 1, 0, 1, 1);
        send(10'h2D2, 10'h12D, 1, 1, 1, 1);
        send(10'h155, 10'h2AA, 0, 1, 0, 1);
        send(10'h3A0, 10'h05F, 1, 0, 0, 1);
        end_scn("R8 mode change mid-period");
    endtask

    initial begin
        t_reset();
        t_low();
        t_high();
        t_pp();
        t_comma();
        t_switch();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule